// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block chooses which of six DMA channels moves the next data word. It also settles which of the active DMA channel and the processor gets the shared external bus. Each channel presents three things: a request line, a 2-bit priority and a continuous-ownership bit. The request line is high only when the channel is enabled and its trigger is pending. A word transfer, once granted, runs until the transfer logic pulses `word_done_i`. The arbiter then picks the owner of the next word in that same cycle, so the new owner holds the grant from the following cycle on, with no idle cycle between words.

Among the requesters, the highest priority level wins. Within that level, channels take one word each in rotating channel-number order. Each level keeps its own rotation pointer. There is one exception: if the current owner has its continuous bit set and is still the best at its level, it keeps the grant. A separate decision gives the external bus to the DMA side or to the processor. It follows a 2-bit policy code. Once the DMA side holds the bus, it keeps it until its current word ends.

Top module: `dma_prio_arb`

## Requirements
- R1: When no channel requests at a decision point (the block is idle, or `word_done_i` is high), the next cycle shows `active_o` low, `grant_o` all zero and `active_ch_o` zero. This also holds right after reset.
- R2: `grant_o` has at most one bit set. A bit is set only while `active_o` is high, and a channel only gains the grant if its request was high at the decision point.
- R3: While `word_done_i` stays low, the owning channel does not change, whatever happens to the other requests.
- R4: If `word_done_i` is high and any channel is requesting, `active_o` is high in the next cycle, with the new owner and no idle cycle.
- R5: Priority codes run from 0 (lowest) to 3 (highest). A requester at a higher level takes the grant at the next word end. The lower channel gets the grant back once no higher channel requests.
- R6: Among non-continuous requesters at the top level, each word goes to the next requesting channel in increasing channel number, wrapping from 5 to 0.
- R7: Each priority level keeps its own rotation pointer. After a grant at a level, that level's pointer moves to the channel after the winner. Grants at other levels leave it unchanged.
- R8: An owner with its continuous bit set that is still requesting keeps the grant over requesters of equal priority.
- R9: A continuous owner loses the grant at the next word end to any requester of higher priority.
- R10: The external bus policy code `bus_policy_i` works as follows when both the active DMA channel and the processor want the bus. With 01, DMA gets the bus. With 10 (equal standing) and with 11, the processor gets it. A lone requester always gets the bus.
- R11: With policy 00, the active channel's priority is compared with `cpu_prio_i`. DMA gets the bus only if its value is strictly greater, so a tie goes to the processor.
- R12: Once DMA holds the external bus, it keeps it until its word ends, even if the policy or the processor priority changes meanwhile.
- R13: `active_ch_o` carries the owner's number in binary (channel 0 as 000 through channel 5 as 101), and the matching bit of `grant_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_req_i | input | 6 | Per-channel request (enabled and triggered) |
| chan_prio_i | input | 12 | Per-channel 2-bit priority, channel c at bits [2c+1:2c] |
| chan_cont_i | input | 6 | Per-channel continuous-ownership bit |
| word_done_i | input | 1 | The current word transfer ends in this cycle |
| dma_ext_req_i | input | 1 | The active channel's word needs the external bus |
| cpu_ext_req_i | input | 1 | The processor wants the external bus |
| cpu_prio_i | input | 2 | Processor priority for policy 00 |
| bus_policy_i | input | 2 | External bus policy code |
| grant_o | output | 6 | One-hot channel grant |
| active_o | output | 1 | A channel owns the current word |
| active_ch_o | output | 3 | Number of the owning channel |
| bus_gnt_dma_o | output | 1 | External bus goes to the active DMA channel |
| bus_gnt_cpu_o | output | 1 | External bus goes to the processor |

## Verification
The bound checker watches several properties on every cycle. It checks that the grant is one-hot and agrees with the channel number, and that the owner stays fixed between word ends. It checks that the grant resumes with no gap, or drops to idle, after a word end. It checks that the two bus grants never overlap, that policy 01 always favours DMA, and that DMA keeps the bus through a word once it has it. Other behaviour depends on the order of grants over several words, which a single-cycle property cannot capture. This covers rotation order within a level, the separate pointer kept for each level, a continuous owner keeping the grant and then losing it to a higher level, and the priority comparison under policy 00. Directed scenarios with known expected owners and bus winners show these.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        POL_COMPARE   = 2'b00,
        POL_DMA_FIRST = 2'b01,
        POL_EQUAL     = 2'b10,
        POL_CPU_FIRST = 2'b11
    } bus_pol_e;

    function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/dma_arb_level_scan.sv
module dma_arb_level_scan #(
    parameter int NCH  = 6,
    parameter int PW   = 2,
    parameter int NLVL = 1 << PW
) (
    input  logic [NCH-1:0]              req_i,
    input  logic [NCH*PW-1:0]           prio_i,
    output logic [NLVL-1:0][NCH-1:0]    lvl_mask_o,
    output logic [PW-1:0]               top_lvl_o,
    output logic                        any_o
);

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign lvl_mask_o[l][c] = req_i[c] && (prio_i[c*PW +: PW] == PW'(l));
        end
    end

    always_comb begin
        top_lvl_o = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (|lvl_mask_o[l]) begin
                top_lvl_o = PW'(l);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
    parameter int NCH = 6,
    parameter int CW  = 3
) (
    input  logic [NCH-1:0] mask_i,
    input  logic [CW-1:0]  start_i,
    output logic           found_o,
    output logic [CW-1:0]  idx_o
);

    int unsigned cand;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        cand    = 0;
        for (int k = 0; k < NCH; k++) begin
            cand = (int'(start_i) + k) % NCH;
            if (!found_o && mask_i[cand]) begin
                found_o = 1'b1;
                idx_o   = CW'(cand);
            end
        end
    end

endmodule

// File: rtl/dma_arb_bus_policy.sv
module dma_arb_bus_policy
    import dma_arb_pkg::*;
#(
    parameter int PW = 2
) (
    input  logic [1:0]    policy_i,
    input  logic [PW-1:0] dma_prio_i,
    input  logic [PW-1:0] cpu_prio_i,
    output logic          dma_wins_o
);

    bus_pol_e pol;

    always_comb begin
        pol = bus_pol_e'(policy_i);
        unique case (pol)
            POL_COMPARE:   dma_wins_o = dma_prio_i > cpu_prio_i;
            POL_DMA_FIRST: dma_wins_o = 1'b1;
            POL_EQUAL:     dma_wins_o = 1'b0;
            POL_CPU_FIRST: dma_wins_o = 1'b0;
            default:       dma_wins_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int NCH = 6,
    parameter int PW  = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NCH-1:0]      chan_req_i,
    input  logic [NCH*PW-1:0]   chan_prio_i,
    input  logic [NCH-1:0]      chan_cont_i,
    input  logic                word_done_i,
    input  logic                dma_ext_req_i,
    input  logic                cpu_ext_req_i,
    input  logic [PW-1:0]       cpu_prio_i,
    input  logic [1:0]          bus_policy_i,
    output logic [NCH-1:0]      grant_o,
    output logic                active_o,
    output logic [$clog2(NCH)-1:0] active_ch_o,
    output logic                bus_gnt_dma_o,
    output logic                bus_gnt_cpu_o
);

    localparam int CW   = $clog2(NCH);
    localparam int NLVL = 1 << PW;

    typedef struct packed {
        logic                       busy;
        logic [CW-1:0]              owner;
        logic [NLVL-1:0][CW-1:0]    rr_ptr;
        logic                       ext_hold;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NLVL-1:0][NCH-1:0] lvl_mask;
    logic [PW-1:0]            top_lvl;
    logic                     any_req;
    logic                     pick_found;
    logic [CW-1:0]            pick_idx;
    logic [PW-1:0]            own_prio;
    logic                     keep_owner;
    logic [CW-1:0]            winner;
    logic                     decide;
    logic                     dma_wins;
    logic                     bus_dma;

    dma_arb_level_scan #(.NCH(NCH), .PW(PW), .NLVL(NLVL)) i_scan (
        .req_i      (chan_req_i),
        .prio_i     (chan_prio_i),
        .lvl_mask_o (lvl_mask),
        .top_lvl_o  (top_lvl),
        .any_o      (any_req)
    );

    dma_arb_rr_pick #(.NCH(NCH), .CW(CW)) i_pick (
        .mask_i  (lvl_mask[top_lvl]),
        .start_i (st_q.rr_ptr[top_lvl]),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    assign own_prio = chan_prio_i[st_q.owner*PW +: PW];

    dma_arb_bus_policy #(.PW(PW)) i_pol (
        .policy_i   (bus_policy_i),
        .dma_prio_i (own_prio),
        .cpu_prio_i (cpu_prio_i),
        .dma_wins_o (dma_wins)
    );

    // The owner stays only if continuous, still requesting and still at the top level.
    assign keep_owner = st_q.busy && chan_cont_i[st_q.owner]
                        && chan_req_i[st_q.owner] && (own_prio == top_lvl);
    assign winner     = keep_owner ? st_q.owner : pick_idx;
    assign decide     = !st_q.busy || word_done_i;

    // Once DMA holds the external bus for a word, it keeps it to the word end.
    assign bus_dma = st_q.busy && dma_ext_req_i
                     && (st_q.ext_hold || !cpu_ext_req_i || dma_wins);

    always_comb begin
        st_d = st_q;
        if (decide) begin
            if (any_req && (keep_owner || pick_found)) begin
                st_d.busy            = 1'b1;
                st_d.owner           = winner;
                st_d.rr_ptr[top_lvl] = CW'(wrap_next(int'(winner), NCH));
            end else begin
                st_d.busy  = 1'b0;
                st_d.owner = '0;
            end
        end
        st_d.ext_hold = bus_dma && !word_done_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        grant_o = '0;
        if (st_q.busy) begin
            grant_o[st_q.owner] = 1'b1;
        end
    end

    assign active_o      = st_q.busy;
    assign active_ch_o   = st_q.busy ? st_q.owner : '0;
    assign bus_gnt_dma_o = bus_dma;
    assign bus_gnt_cpu_o = cpu_ext_req_i && !bus_dma;

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
    parameter int NCH = 6,
    parameter int PW  = 2
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [NCH-1:0]          chan_req_i,
    input logic                    word_done_i,
    input logic                    dma_ext_req_i,
    input logic                    cpu_ext_req_i,
    input logic [1:0]              bus_policy_i,
    input logic [NCH-1:0]          grant_o,
    input logic                    active_o,
    input logic [$clog2(NCH)-1:0]  active_ch_o,
    input logic                    bus_gnt_dma_o,
    input logic                    bus_gnt_cpu_o
);

    assert_grant_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o) && (active_o == (|grant_o)));

    assert_grant_was_requested_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(active_o) |-> (($past(chan_req_i) & grant_o) != '0));

    assert_owner_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && !word_done_i) |=> (active_o && $stable(active_ch_o)));

    assert_no_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!active_o || word_done_i) && (|chan_req_i)) |=> active_o);

    assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!active_o || word_done_i) && !(|chan_req_i)) |=> (!active_o && active_ch_o == '0));

    assert_chan_code_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_o |-> ((int'(active_ch_o) < NCH) && grant_o[active_ch_o]));

    assert_bus_mutex_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_gnt_dma_o && bus_gnt_cpu_o));

    assert_dma_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_policy_i == 2'b01 && active_o && dma_ext_req_i) |-> bus_gnt_dma_o);

    assert_bus_kept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_gnt_dma_o && !word_done_i) |=> (!dma_ext_req_i || bus_gnt_dma_o));

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH), .PW(PW)) i_chk (.*);

// File: tb/test_dma_prio_arb.sv
module test_dma_prio_arb;

    localparam int NCH = 6;
    localparam int PW  = 2;

    logic                clk_i = 1'b0;
    logic                rst_ni;
    logic [NCH-1:0]      chan_req_i;
    logic [NCH*PW-1:0]   chan_prio_i;
    logic [NCH-1:0]      chan_cont_i;
    logic                word_done_i;
    logic                dma_ext_req_i;
    logic                cpu_ext_req_i;
    logic [PW-1:0]       cpu_prio_i;
    logic [1:0]          bus_policy_i;
    logic [NCH-1:0]      grant_o;
    logic                active_o;
    logic [2:0]          active_ch_o;
    logic                bus_gnt_dma_o;
    logic                bus_gnt_cpu_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk_i = ~clk_i;

    dma_prio_arb #(.NCH(NCH), .PW(PW)) i_dma_prio_arb (.*);

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic set_chan(input int c, input bit r, input int p, input bit cont);
        chan_req_i[c]          = r;
        chan_prio_i[c*PW +: PW] = PW'(p);
        chan_cont_i[c]         = cont;
    endtask

    task automatic expect_owner(input string req, input int ch);
        check(req, int'(active_o), 1);
        check(req, int'(active_ch_o), ch);
        check(req, int'(grant_o), 1 << ch);
    endtask

    task automatic do_reset();
        rst_ni        = 1'b0;
        chan_req_i    = '0;
        chan_prio_i   = '0;
        chan_cont_i   = '0;
        word_done_i   = 1'b0;
        dma_ext_req_i = 1'b0;
        cpu_ext_req_i = 1'b0;
        cpu_prio_i    = '0;
        bus_policy_i  = '0;
        step();
        step();
        rst_ni = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset active", int'(active_o), 0);
        check("R1 reset grant", int'(grant_o), 0);
        check("R1 reset chan", int'(active_ch_o), 0);
        step();
        check("R1 idle no request", int'(active_o), 0);
    endtask

    task automatic t_preempt();
        do_reset();
        set_chan(1, 1, 0, 0);
        step();
        expect_owner("R4 first grant", 1);
        set_chan(4, 1, 2, 0);
        step();
        expect_owner("R3 owner held mid word", 1);
        step();
        expect_owner("R3 owner held mid word 2", 1);
        word_done_i = 1'b1;
        step();
        expect_owner("R5 higher takes over", 4);
        step();
        expect_owner("R5 higher keeps", 4);
        set_chan(4, 0, 2, 0);
        step();
        expect_owner("R5 lower resumes", 1);
        word_done_i = 1'b0;
    endtask

    task automatic t_round_robin();
        do_reset();
        set_chan(0, 1, 3, 0);
        set_chan(2, 1, 3, 0);
        set_chan(5, 1, 3, 0);
        set_chan(3, 0, 3, 0);
        step();
        expect_owner("R6 rr first", 0);
        word_done_i = 1'b1;
        step();
        expect_owner("R6 rr second", 2);
        step();
        expect_owner("R13 rr third ch5", 5);
        check("R13 code 101", int'(active_ch_o), 3'b101);
        step();
        expect_owner("R6 rr wrap", 0);
        word_done_i = 1'b0;
    endtask

    task automatic t_level_ptr();
        do_reset();
        set_chan(0, 1, 1, 0);
        set_chan(1, 1, 1, 0);
        step();
        expect_owner("R7 level1 first", 0);
        set_chan(4, 1, 2, 0);
        word_done_i = 1'b1;
        step();
        expect_owner("R7 level2 cuts in", 4);
        set_chan(4, 0, 2, 0);
        step();
        expect_owner("R7 level1 pointer kept", 1);
        word_done_i = 1'b0;
    endtask

    task automatic t_continuous();
        do_reset();
        set_chan(1, 1, 2, 1);
        set_chan(2, 1, 2, 0);
        step();
        expect_owner("R8 cont first", 1);
        word_done_i = 1'b1;
        step();
        expect_owner("R8 cont keeps", 1);
        step();
        expect_owner("R8 cont keeps again", 1);
        set_chan(3, 1, 3, 0);
        step();
        expect_owner("R9 higher beats cont", 3);
        set_chan(3, 0, 3, 0);
        step();
        expect_owner("R6 level2 rotates on", 2);
        chan_req_i = '0;
        step();
        check("R1 idle active", int'(active_o), 0);
        check("R1 idle grant", int'(grant_o), 0);
        check("R1 idle chan", int'(active_ch_o), 0);
        word_done_i = 1'b0;
    endtask

    task automatic bus_case(input string req, input int pol, input int cprio,
                            input bit dreq, input bit creq, input bit exp_dma);
        bus_policy_i  = 2'(pol);
        cpu_prio_i    = PW'(cprio);
        dma_ext_req_i = dreq;
        cpu_ext_req_i = creq;
        #1;
        check(req, int'(bus_gnt_dma_o), int'(exp_dma));
        check(req, int'(bus_gnt_cpu_o), int'(creq && !exp_dma));
        dma_ext_req_i = 1'b0;
        cpu_ext_req_i = 1'b0;
        step();
    endtask

    task automatic t_bus_policy();
        do_reset();
        set_chan(2, 1, 2, 0);
        step();
        expect_owner("R4 bus setup", 2);
        bus_case("R11 dma higher", 0, 1, 1, 1, 1);
        bus_case("R11 tie to cpu", 0, 2, 1, 1, 0);
        bus_case("R11 cpu higher", 0, 3, 1, 1, 0);
        bus_case("R10 dma first", 1, 3, 1, 1, 1);
        bus_case("R10 equal cpu first", 2, 0, 1, 1, 0);
        bus_case("R10 dma last", 3, 0, 1, 1, 0);
        bus_case("R10 dma alone", 3, 0, 1, 0, 1);
        bus_case("R10 cpu alone", 1, 0, 0, 1, 0);
    endtask

    task automatic t_bus_hold();
        do_reset();
        set_chan(2, 1, 2, 0);
        step();
        bus_policy_i  = 2'b01;
        dma_ext_req_i = 1'b1;
        cpu_ext_req_i = 1'b1;
        #1;
        check("R12 dma takes bus", int'(bus_gnt_dma_o), 1);
        step();
        bus_policy_i = 2'b11;
        #1;
        check("R12 dma keeps bus", int'(bus_gnt_dma_o), 1);
        check("R12 cpu waits", int'(bus_gnt_cpu_o), 0);
        word_done_i = 1'b1;
        #1;
        check("R12 kept in last cycle", int'(bus_gnt_dma_o), 1);
        step();
        word_done_i = 1'b0;
        #1;
        check("R12 cpu after word end", int'(bus_gnt_cpu_o), 1);
        check("R12 dma released", int'(bus_gnt_dma_o), 0);
        dma_ext_req_i = 1'b0;
        cpu_ext_req_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_preempt();
        t_round_robin();
        t_level_ptr();
        t_continuous();
        t_bus_policy();
        t_bus_hold();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule